// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block produces a set of divided output clocks from one fast internal clock and removes or restores them on request without ever emitting a shortened pulse. The outputs form three groups: a CPU group, a gated PCI group, and one PCI output that keeps running when the PCI group is stopped. Each output has its own divider. A stop never cuts a pulse short, because a divider can only begin a high phase at the end of a whole low phase. Once a high phase has begun, it always runs to its end.

Three active-low control pins may change at any time with no relation to the clock. Each pin passes through a two-flop synchronizer before it is used. The first pin stops the CPU group. The second stops the gated PCI group. The third is a power-down that parks every output. A configuration word holds one enable bit per output. A stopped or disabled output rests low and always comes back with a full-width high phase.

Top module: `clkstop`

## Requirements
- R1: While `rstN` is low, every output clock is low.
- R2: A running CPU-group output is high for exactly CPU_HALF fast-clock cycles and then low for exactly CPU_HALF cycles. A running PCI output does the same with PCI_HALF cycles.
- R3: A stopped or disabled output is held low. No output is ever high for more than its nominal high width.
- R4: No pulse is ever truncated. Every high pulse, including the first one after a restart, has the nominal width. Every low interval is a whole multiple of the nominal half period.
- R5: When `cpuStopN` is low, only the CPU-group outputs stop. The PCI outputs keep running.
- R6: When `pciStopN` is low, the gated PCI outputs stop. `pciFreeClk` ignores this pin and keeps running. The CPU group also keeps running.
- R7: Stop latency. Each control pin is sampled by a two-flop synchronizer. No rising edge appears later than 2 fast cycles after a stop request. The output is low from HALF+3 cycles after the request and stays low.
- R8: Resume latency. After a stop pin returns high, the first rising edge appears no earlier than 3 cycles and no later than HALF+3 cycles after the release.
- R9: When `pwrDownN` is low, every output stops, including `pciFreeClk`. The last high pulse finishes at full width, and all outputs are low from PCI_HALF+3 cycles after the request.
- R10: Enable bit i of `outEn` gates output i: 1 lets it run and 0 holds it low. The bits are laid out as CPU outputs at [NCPU-1:0], gated PCI outputs at [NCPU+NPCI-1:NCPU], and the free PCI output in the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuStopN | input | 1 | Asynchronous active-low stop for the CPU group |
| pciStopN | input | 1 | Asynchronous active-low stop for the gated PCI group |
| pwrDownN | input | 1 | Asynchronous active-low power-down for all outputs |
| outEn | input | NCPU+NPCI+1 | Per-output enable, 1 = run |
| cpuClk | output | NCPU | CPU-group divided clocks |
| pciClk | output | NPCI | Gated PCI-group divided clocks |
| pciFreeClk | output | 1 | PCI clock that ignores the PCI stop |

## Verification
The bench builds the block with three CPU outputs at a half period of 2 cycles and six gated PCI outputs at an odd half period of 5 cycles. The two groups therefore fall in and out of phase with each other, so a stop request lands at every point of a pulse. The short CPU half period puts the stop and release boundaries within a few cycles of the request. The odd PCI half period shows whether a low interval is counted as a whole multiple of the half period. Stop requests are issued at each cycle offset within a PCI period, so both latency bounds are measured at their worst phase.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Group run strobes, already synchronized, from control to datapath
  typedef struct packed {
    logic cpuGo;
    logic pciGo;
    logic allGo;
  } runStrobes_t;

  localparam int unsigned NUM_CTRL_PINS = 3;

endpackage

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuStopN,
  input  logic        pciStopN,
  input  logic        pwrDownN,
  output runStrobes_t strobes
);

  logic [NUM_CTRL_PINS-1:0] rawN;
  logic [NUM_CTRL_PINS-1:0][SYNC_STAGES-1:0] chain;
  logic [NUM_CTRL_PINS-1:0] syncN;

  assign rawN = {pwrDownN, pciStopN, cpuStopN};

  // The chains reset to the "stopped" value, so outputs start parked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      for (int p = 0; p < NUM_CTRL_PINS; p++) begin
        chain[p] <= {chain[p][SYNC_STAGES-2:0], rawN[p]};
      end
    end
  end

  for (genvar p = 0; p < NUM_CTRL_PINS; p++) begin : g_tap
    assign syncN[p] = chain[p][SYNC_STAGES-1];
  end

  // Power-down overrides both group stops
  assign strobes.allGo = syncN[2];
  assign strobes.cpuGo = syncN[0] & syncN[2];
  assign strobes.pciGo = syncN[1] & syncN[2];

endmodule

// File: rtl/clkstop_div.sv
module clkstop_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic clkOut
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          phase;

  // run is looked at only when a low phase ends, so pulses stay whole
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= phase ? 1'b0 : run;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign clkOut = phase;

endmodule

// File: rtl/clkstop_datapath.sv
module clkstop_datapath
  import clkstop_pkg::*;
#(
  parameter int NCPU     = 3,
  parameter int NPCI     = 6,
  parameter int CPU_HALF = 2,
  parameter int PCI_HALF = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  runStrobes_t            strobes,
  input  logic [NCPU+NPCI:0]     outEn,
  output logic [NCPU+NPCI:0]     outClk
);

  localparam int NOUT = NCPU + NPCI + 1;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    logic groupGo;
    if (i < NCPU) begin : g_cpu
      assign groupGo = strobes.cpuGo;
      clkstop_div #(.HALF(CPU_HALF)) u_div (
        .clk(clk), .rstN(rstN), .run(groupGo & outEn[i]), .clkOut(outClk[i])
      );
    end else if (i < NCPU + NPCI) begin : g_pci
      assign groupGo = strobes.pciGo;
      clkstop_div #(.HALF(PCI_HALF)) u_div (
        .clk(clk), .rstN(rstN), .run(groupGo & outEn[i]), .clkOut(outClk[i])
      );
    end else begin : g_free
      assign groupGo = strobes.allGo;
      clkstop_div #(.HALF(PCI_HALF)) u_div (
        .clk(clk), .rstN(rstN), .run(groupGo & outEn[i]), .clkOut(outClk[i])
      );
    end
  end

endmodule

// File: rtl/clkstop.sv
module clkstop
  import clkstop_pkg::*;
#(
  parameter int NCPU        = 3,
  parameter int NPCI        = 6,
  parameter int CPU_HALF    = 2,
  parameter int PCI_HALF    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuStopN,
  input  logic                 pciStopN,
  input  logic                 pwrDownN,
  input  logic [NCPU+NPCI:0]   outEn,
  output logic [NCPU-1:0]      cpuClk,
  output logic [NPCI-1:0]      pciClk,
  output logic                 pciFreeClk
);

  runStrobes_t          strobes;
  logic [NCPU+NPCI:0]   outClk;

  clkstop_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .pwrDownN(pwrDownN), .strobes(strobes)
  );

  clkstop_datapath #(
    .NCPU(NCPU), .NPCI(NPCI), .CPU_HALF(CPU_HALF), .PCI_HALF(PCI_HALF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .outEn(outEn), .outClk(outClk)
  );

  assign cpuClk     = outClk[NCPU-1:0];
  assign pciClk     = outClk[NCPU+NPCI-1:NCPU];
  assign pciFreeClk = outClk[NCPU+NPCI];

endmodule

// File: rtl/clkstop_checker.sv
module clkstop_checker #(
  parameter int NCPU     = 3,
  parameter int NPCI     = 6,
  parameter int CPU_HALF = 2,
  parameter int PCI_HALF = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [NCPU+NPCI:0] outEn,
  input logic [NCPU-1:0]    cpuClk,
  input logic [NPCI-1:0]    pciClk,
  input logic               pciFreeClk
);

  localparam int NOUT = NCPU + NPCI + 1;

  logic [NOUT-1:0] outs;
  assign outs = {pciFreeClk, pciClk, cpuClk};

  // R1: outputs are parked while reset is held
  a_r1_reset_low: assert property (@(negedge clk) !rstN |-> outs == '0);

  for (genvar i = 0; i < NOUT; i++) begin : g_mon
    localparam int H = (i < NCPU) ? CPU_HALF : PCI_HALF;
    logic [15:0] hiCnt;
    logic [15:0] loCnt;
    logic        seenHigh;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiCnt    <= '0;
        loCnt    <= '0;
        seenHigh <= 1'b0;
      end else if (outs[i]) begin
        hiCnt    <= (hiCnt == 16'hFFFF) ? hiCnt : hiCnt + 16'd1;
        loCnt    <= '0;
        seenHigh <= 1'b1;
      end else begin
        hiCnt <= '0;
        loCnt <= (loCnt == 16'hFFFF) ? loCnt : loCnt + 16'd1;
      end
    end

    // R2: each high pulse lasts exactly the nominal half period
    a_r2_high_width: assert property (@(posedge clk) disable iff (!rstN)
      $fell(outs[i]) |-> hiCnt == 16'(H));

    // R3: never held high beyond its nominal width
    a_r3_not_stuck_high: assert property (@(posedge clk) disable iff (!rstN)
      outs[i] |-> hiCnt < 16'(H));

    // R4: low intervals are whole multiples of the half period
    a_r4_low_whole: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(outs[i]) && seenHigh && loCnt != 16'hFFFF)
        |-> (loCnt >= 16'(H)) && ((loCnt % 16'(H)) == 16'd0));

    // R10: a rising edge needs the enable bit at the deciding edge
    a_r10_enable_gates: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outs[i]) |-> $past(outEn[i]));
  end

endmodule

bind clkstop clkstop_checker #(
  .NCPU(NCPU), .NPCI(NPCI), .CPU_HALF(CPU_HALF), .PCI_HALF(PCI_HALF)
) u_chk (
  .clk(clk), .rstN(rstN), .outEn(outEn), .cpuClk(cpuClk),
  .pciClk(pciClk), .pciFreeClk(pciFreeClk)
);

// File: tb/clkstop_bench.sv
module clkstop_bench;

  localparam int NCPU = 3;
  localparam int NPCI = 6;
  localparam int CH   = 2;
  localparam int PH   = 5;
  localparam int NOUT = NCPU + NPCI + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuStopN = 1'b1, pciStopN = 1'b1, pwrDownN = 1'b1;
  logic [NOUT-1:0] outEn = '1;
  logic [NCPU-1:0] cpuClk;
  logic [NPCI-1:0] pciClk;
  logic pciFreeClk;
  logic [NOUT-1:0] outs;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  clkstop #(.NCPU(NCPU), .NPCI(NPCI), .CPU_HALF(CH), .PCI_HALF(PH)) u_clkstop (
    .clk(clk), .rstN(rstN), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .pwrDownN(pwrDownN), .outEn(outEn), .cpuClk(cpuClk), .pciClk(pciClk),
    .pciFreeClk(pciFreeClk)
  );

  assign outs = {pciFreeClk, pciClk, cpuClk};

  function automatic int halfOf(int i);
    return (i < NCPU) ? CH : PH;
  endfunction

  function automatic string tagName(int n);
    case (n)
      2: return "R2";
      5: return "R5";
      6: return "R6";
      9: return "R9";
      10: return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pulse-width monitor (R2, R4): sampled at the falling edge of clk
  int runLen [NOUT];
  bit seenRise [NOUT];
  logic [NOUT-1:0] prevOut;
  int shortHigh = 0, badLow = 0, highPulses = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevOut <= '0;
      for (int i = 0; i < NOUT; i++) begin
        runLen[i] = 0;
        seenRise[i] = 0;
      end
    end else begin
      for (int i = 0; i < NOUT; i++) begin
        if (outs[i] != prevOut[i]) begin
          if (prevOut[i]) begin
            highPulses++;
            if (runLen[i] != halfOf(i)) shortHigh++;
          end else begin
            if (seenRise[i] && (runLen[i] < halfOf(i) || runLen[i] % halfOf(i) != 0))
              badLow++;
            seenRise[i] = 1;
          end
          runLen[i] = 1;
        end else begin
          runLen[i] = runLen[i] + 1;
        end
      end
      prevOut <= outs;
    end
  end

  // Vector: {cpuStopN, pciStopN, pwrDownN}, enable, expected running set, tag
  localparam logic [26:0] VECS [0:8] = '{
    {3'b111, 10'h3FF, 10'h3FF, 4'd2},
    {3'b011, 10'h3FF, 10'h3F8, 4'd5},
    {3'b101, 10'h3FF, 10'h207, 4'd6},
    {3'b001, 10'h3FF, 10'h200, 4'd6},
    {3'b110, 10'h3FF, 10'h000, 4'd9},
    {3'b000, 10'h3FF, 10'h000, 4'd9},
    {3'b111, 10'h155, 10'h155, 4'd10},
    {3'b011, 10'h2AA, 10'h2A8, 4'd10},
    {3'b101, 10'h1FF, 10'h007, 4'd6}
  };

  // Stop then resume one output through one pin; measures R7, R8, R4
  task automatic stopResume(input int pin, input int idx, input int offs);
    int h;
    logic prev;
    int lateRise, highLate, firstRise, hiW;
    h = halfOf(idx);
    {cpuStopN, pciStopN, pwrDownN} = 3'b111;
    outEn = '1;
    repeat (4 * PH + offs) @(negedge clk);
    prev = outs[idx];
    if (pin == 0) cpuStopN = 0; else if (pin == 1) pciStopN = 0; else pwrDownN = 0;
    lateRise = 0; highLate = 0;
    for (int k = 1; k <= h + 3 + 4 * h; k++) begin
      @(negedge clk);
      if (outs[idx] && !prev && k >= 3) lateRise++;
      if (outs[idx] && k >= h + 3) highLate++;
      prev = outs[idx];
    end
    check(lateRise == 0, "R7 rise after stop", lateRise, 0);
    check(highLate == 0, "R7 high after stop window", highLate, 0);
    if (pin == 2) check(outs == '0, "R9 all parked", int'(outs), 0);
    if (pin == 0) cpuStopN = 1; else if (pin == 1) pciStopN = 1; else pwrDownN = 1;
    firstRise = 0;
    for (int k = 1; k <= 3 * h + 6 && firstRise == 0; k++) begin
      @(negedge clk);
      if (outs[idx] && !prev) firstRise = k;
      prev = outs[idx];
    end
    check(firstRise >= 3 && firstRise <= h + 3, "R8 resume latency", firstRise, h + 3);
    hiW = 1;
    for (int k = 0; k < 3 * h && outs[idx]; k++) begin
      @(negedge clk);
      if (outs[idx]) hiW++;
    end
    check(hiW == h, "R4 first pulse width", hiW, h);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(outs == '0, "R1 reset low", int'(outs), 0);
    rstN = 1'b1;

    // Table walk: R2, R3, R5, R6, R9, R10
    for (int v = 0; v < 9; v++) begin
      logic [NOUT-1:0] exp;
      int rises [NOUT];
      logic [NOUT-1:0] anyHigh;
      logic [NOUT-1:0] last;
      {cpuStopN, pciStopN, pwrDownN} = VECS[v][26:24];
      outEn = VECS[v][23:14];
      exp = VECS[v][13:4];
      repeat (6 * PH) @(negedge clk);
      anyHigh = '0;
      last = outs;
      for (int i = 0; i < NOUT; i++) rises[i] = 0;
      for (int k = 0; k < 8 * PH; k++) begin
        @(negedge clk);
        for (int i = 0; i < NOUT; i++) begin
          if (outs[i] && !last[i]) rises[i]++;
        end
        anyHigh |= outs;
        last = outs;
      end
      for (int i = 0; i < NOUT; i++) begin
        if (exp[i])
          check(rises[i] == 8 * PH / (2 * halfOf(i)), tagName(int'(VECS[v][3:0])),
                rises[i], 8 * PH / (2 * halfOf(i)));
        else
          check(rises[i] == 0 && !anyHigh[i], "R3 parked low", rises[i] + int'(anyHigh[i]), 0);
      end
    end

    // Latency sweeps over every phase of a PCI period: R7, R8, R4
    for (int offs = 0; offs < 2 * PH; offs++) begin
      stopResume(1, NCPU, offs);
      stopResume(0, 0, offs);
    end
    stopResume(2, NOUT - 1, 1);
    stopResume(2, NOUT - 1, 4);

    // Pulse-shape summary from the monitor: R2, R4
    check(highPulses > 100, "R2 pulses observed", highPulses, 101);
    check(shortHigh == 0, "R2 high width", shortHigh, 0);
    check(badLow == 0, "R4 low width", badLow, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule